// File: doc/BRIEF.md
# Width-Adaptive Boot Image Loader

This block copies a boot image out of a slow word-addressed memory into its final locations after reset, and reports where program execution should begin. The image may sit on an 8-, 16- or 32-bit wide device. Each memory word read returns 32 bits, but only the low bus-width bits of each read are meaningful. The image describes its own width in its first word, so the same engine serves every board variant without strapping.

After the width word, the image holds one control word and then a list of sections. Each section gives a length, a destination address and that many data words. Every logical 32-bit value is rebuilt from one, two or four narrow reads, lowest piece first. The loader stops at a section whose length is zero. It then pulses its done output, with the destination of the first section shown as the start address.

Reads and writes share one request channel, a valid/ready handshake. Once the loader raises valid, it holds the address, direction and write data unchanged until ready is seen high at a clock edge. Only one read is outstanding at a time. The response channel has no back-pressure. The loader takes a response only while it is waiting for a read it has issued, and drops any response that arrives at another time, including during a write.

Top module: `boot_image_loader`

## Requirements
- R1: After reset, busy, done, the request valid, the start address and the control word output are all low or zero.
- R2: A start pulse while idle makes the first read go to the base address. Busy then stays high until done rises. Done is high for exactly one cycle, and busy is low in that cycle.
- R3: The raw 32-bit value of the first read selects the width: 8, 16 or 32. Any other value ends the run with done, with start address 0, with no further reads and with no writes.
- R4: Each later read is masked to its low width bits. A logical value takes 32/width reads, and piece i lands at bit offset width*i. Bits above the width in a raw read have no effect.
- R5: The read address moves on by 32/width after the width word, and then by one after each read.
- R6: The first logical value after the width word is kept on the control word output until the next run. Its value has no effect on the rest of the run.
- R7: A section length of zero ends the run with a done pulse, with no write for that section. If it is the first section, the start address is 0.
- R8: A nonzero length is followed by a destination and then length data words. Each data word is written to the destination, and the destination then increments by one.
- R9: The start address is the destination of the first section. Later sections do not change it.
- R10: A request keeps valid, address, direction and write data stable until it is accepted. Responses that arrive while no read is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when the loader is idle |
| base_addr_i | input | AW | Word address of the width word |
| mem_req_valid_o | output | 1 | Request valid |
| mem_req_ready_i | input | 1 | Request accepted when high together with valid |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | AW | Word address of the request |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid (no back-pressure) |
| mem_rsp_data_i | input | 32 | Raw read data |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| start_addr_o | output | 32 | Program start address reported at done |
| ctrl_word_o | output | 32 | Control word taken from the image |

## Verification
A width code held wrongly inside the loader splits or merges logical values at the wrong points. This shows up at the ports as misplaced write addresses and data within the first section, a few reads after the control word. A piece index that is off by one corrupts the control word output as soon as it is assembled. A missing mask shows up as garbage in the upper bits of written data. A remaining-count error shows up at the end of a section: the number of writes is wrong, or the next length is read from a data word, and either one changes the write count and the cycle of the done pulse. A request that moves while it is stalled, or a stray response that is taken, changes the destination contents within one transfer.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bus_w_e;

  typedef enum logic [1:0] {
    FLD_CTRL,
    FLD_LEN,
    FLD_DEST,
    FLD_DATA
  } field_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_WWAIT,
    ST_RREQ,
    ST_RWAIT,
    ST_STORE,
    ST_DONE
  } state_e;
endpackage

// File: rtl/boot_ldr_width_decode.sv
module boot_ldr_width_decode
  import boot_ldr_pkg::*;
(
  input  logic [WORD_W-1:0] raw_i,
  output logic              valid_o,
  output bus_w_e            code_o,
  output logic [STEP_W-1:0] step_o
);
  always_comb begin
    valid_o = 1'b1;
    code_o  = BW_32;
    step_o  = STEP_W'(1);
    unique case (raw_i)
      WORD_W'(8):  begin code_o = BW_8;  step_o = STEP_W'(4); end
      WORD_W'(16): begin code_o = BW_16; step_o = STEP_W'(2); end
      WORD_W'(32): begin code_o = BW_32; step_o = STEP_W'(1); end
      default:     valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/boot_ldr_piece_merge.sv
module boot_ldr_piece_merge
  import boot_ldr_pkg::*;
(
  input  bus_w_e            code_i,
  input  logic [1:0]        idx_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic [WORD_W-1:0] merged_o,
  output logic              last_o
);
  localparam int unsigned LANES = WORD_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic       hit;
    logic [7:0] src;
    always_comb begin
      unique case (code_i)
        BW_8: begin
          hit = (idx_i == 2'(k));
          src = raw_i[7:0];
        end
        BW_16: begin
          hit = (idx_i == 2'(k / 2));
          src = raw_i[8*(k%2) +: 8];
        end
        BW_32: begin
          hit = 1'b1;
          src = raw_i[8*k +: 8];
        end
        default: begin
          hit = 1'b0;
          src = 8'h00;
        end
      endcase
    end
    assign merged_o[8*k +: 8] = hit ? src : acc_i[8*k +: 8];
  end

  always_comb begin
    unique case (code_i)
      BW_8:    last_o = (idx_i == 2'd3);
      BW_16:   last_o = (idx_i == 2'd1);
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/boot_image_loader.sv
module boot_image_loader
  import boot_ldr_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     base_addr_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [AW-1:0]     mem_req_addr_o,
  output logic [WORD_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] start_addr_o,
  output logic [WORD_W-1:0] ctrl_word_o
);
  state_e            state_q;
  bus_w_e            code_q;
  field_e            field_q;
  logic [AW-1:0]     addr_q;
  logic [1:0]        idx_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] remain_q;
  logic [WORD_W-1:0] dest_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] start_q;
  logic [WORD_W-1:0] ctrl_q;
  logic              first_q;

  logic              dec_valid;
  bus_w_e            dec_code;
  logic [STEP_W-1:0] dec_step;
  logic [WORD_W-1:0] merged;
  logic              last_piece;

  boot_ldr_width_decode u_dec (
    .raw_i   (mem_rsp_data_i),
    .valid_o (dec_valid),
    .code_o  (dec_code),
    .step_o  (dec_step)
  );

  boot_ldr_piece_merge u_merge (
    .code_i   (code_q),
    .idx_i    (idx_q),
    .acc_i    (acc_q),
    .raw_i    (mem_rsp_data_i),
    .merged_o (merged),
    .last_o   (last_piece)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      code_q   <= BW_32;
      field_q  <= FLD_CTRL;
      addr_q   <= '0;
      idx_q    <= '0;
      acc_q    <= '0;
      remain_q <= '0;
      dest_q   <= '0;
      wdata_q  <= '0;
      start_q  <= '0;
      ctrl_q   <= '0;
      first_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q  <= base_addr_i;
            state_q <= ST_WREQ;
          end
        end
        ST_WREQ: begin
          if (mem_req_ready_i) state_q <= ST_WWAIT;
        end
        ST_WWAIT: begin
          if (mem_rsp_valid_i) begin
            start_q <= '0;
            first_q <= 1'b1;
            idx_q   <= '0;
            acc_q   <= '0;
            field_q <= FLD_CTRL;
            if (dec_valid) begin
              code_q  <= dec_code;
              addr_q  <= addr_q + AW'(dec_step);
              state_q <= ST_RREQ;
            end else begin
              state_q <= ST_DONE;
            end
          end
        end
        ST_RREQ: begin
          if (mem_req_ready_i) begin
            addr_q  <= addr_q + AW'(1);
            state_q <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (mem_rsp_valid_i) begin
            state_q <= ST_RREQ;
            if (!last_piece) begin
              acc_q <= merged;
              idx_q <= idx_q + 2'd1;
            end else begin
              acc_q <= '0;
              idx_q <= '0;
              unique case (field_q)
                FLD_CTRL: begin
                  ctrl_q  <= merged;
                  field_q <= FLD_LEN;
                end
                FLD_LEN: begin
                  if (merged == '0) begin
                    state_q <= ST_DONE;
                  end else begin
                    remain_q <= merged;
                    field_q  <= FLD_DEST;
                  end
                end
                FLD_DEST: begin
                  dest_q <= merged;
                  if (first_q) begin
                    start_q <= merged;
                    first_q <= 1'b0;
                  end
                  field_q <= FLD_DATA;
                end
                default: begin
                  wdata_q <= merged;
                  state_q <= ST_STORE;
                end
              endcase
            end
          end
        end
        ST_STORE: begin
          if (mem_req_ready_i) begin
            dest_q   <= dest_q + WORD_W'(1);
            remain_q <= remain_q - WORD_W'(1);
            field_q  <= (remain_q == WORD_W'(1)) ? FLD_LEN : FLD_DATA;
            state_q  <= ST_RREQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_WREQ) || (state_q == ST_RREQ) || (state_q == ST_STORE);
  assign mem_req_write_o = (state_q == ST_STORE);
  assign mem_req_addr_o  = (state_q == ST_STORE) ? dest_q[AW-1:0] : addr_q;
  assign mem_req_wdata_o = wdata_q;
  assign busy_o          = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o          = (state_q == ST_DONE);
  assign start_addr_o    = start_q;
  assign ctrl_word_o     = ctrl_q;
endmodule

// File: rtl/boot_image_loader_chk.sv
module boot_image_loader_chk
  import boot_ldr_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_write_o,
  input logic [AW-1:0]     mem_req_addr_o,
  input logic [WORD_W-1:0] mem_req_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] start_addr_o,
  input logic [WORD_W-1:0] ctrl_word_o
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)
       && $stable(mem_req_wdata_o)));

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o);

  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(ctrl_word_o));

  a_r9_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(start_addr_o));
endmodule

bind boot_image_loader boot_image_loader_chk #(.AW(AW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_write_o (mem_req_write_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_wdata_o (mem_req_wdata_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .start_addr_o    (start_addr_o),
  .ctrl_word_o     (ctrl_word_o)
);

// File: tb/boot_image_loader_tb_top.sv
`timescale 1ns/1ps
module boot_image_loader_tb_top;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [31:0]   mem_req_wdata;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_data;
  logic          busy, done;
  logic [31:0]   start_addr, ctrl_word;

  always #10 clk = ~clk;

  boot_image_loader #(.AW(AW)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .base_addr_i     (base_addr_i),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_ready_i (mem_req_ready),
    .mem_req_write_o (mem_req_write),
    .mem_req_addr_o  (mem_req_addr),
    .mem_req_wdata_o (mem_req_wdata),
    .mem_rsp_valid_i (mem_rsp_valid),
    .mem_rsp_data_i  (mem_rsp_data),
    .busy_o          (busy),
    .done_o          (done),
    .start_addr_o    (start_addr),
    .ctrl_word_o     (ctrl_word)
  );

  logic [31:0] mem [1024];
  int checks = 0;
  int errors = 0;
  int lat = 1;
  bit stall_en = 0;
  bit spur_en = 0;
  int rd_count = 0;
  int wr_count = 0;
  logic [AW-1:0] first_rd_addr = '0;
  int wp = 0;
  int bw = 32;

  // memory responder
  initial begin : responder
    bit pend;
    int dly;
    logic [9:0] paddr;
    logic [7:0] lfsr;
    pend = 0; dly = 0; paddr = '0; lfsr = 8'h5a;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[9:0]] = mem_req_wdata;
          wr_count++;
        end else begin
          if (rd_count == 0) first_rd_addr = mem_req_addr;
          rd_count++;
          pend = 1; dly = lat; paddr = mem_req_addr[9:0];
        end
      end else if (pend) begin
        if (dly <= 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[paddr];
          pend = 0;
        end else dly--;
      end else if (spur_en && lfsr[0]) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= 32'hDEAD_BEEF;
      end
      mem_req_ready <= stall_en ? lfsr[1] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_image(input int base, input logic [31:0] wword, input int width);
    bw = width;
    mem[base] = wword;
    wp = base + ((width == 8 || width == 16 || width == 32) ? 32 / width : 1);
  endtask

  task automatic put_val(input logic [31:0] v, input logic [31:0] junk);
    logic [31:0] mask;
    mask = (bw == 32) ? 32'hFFFF_FFFF : ((32'd1 << bw) - 32'd1);
    for (int i = 0; i < 32 / bw; i++) begin
      mem[wp] = ((v >> (bw * i)) & mask) | (junk & ~mask);
      wp++;
    end
  endtask

  task automatic run_boot(input int base, input string req, output logic [31:0] sa);
    bit got, busy_ok;
    got = 0; busy_ok = 1; sa = '0;
    rd_count = 0; wr_count = 0;
    @(negedge clk);
    base_addr_i = AW'(base);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 20000 && !got; c++) begin
      if (done) begin
        got = 1;
        sa = start_addr;
        chk({req, " busy low at done"}, {31'd0, busy}, 32'd0);
      end else begin
        if (!busy) busy_ok = 0;
        @(negedge clk);
      end
    end
    chk({req, " done seen"}, {31'd0, got}, 32'd1);
    chk({req, " busy held until done"}, {31'd0, busy_ok}, 32'd1);
    @(negedge clk);
    chk({req, " done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  // R1
  task automatic t_reset;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 start", start_addr, 32'd0);
    chk("R1 ctrl", ctrl_word, 32'd0);
  endtask

  // R2 R5 R7 R8 R9 with 32-bit width
  task automatic t_wide32;
    logic [31:0] sa;
    begin_image(32'h040, 32'd32, 32);
    put_val(32'h1234_5678, 0);
    put_val(3, 0); put_val(32'h200, 0);
    for (int i = 0; i < 3; i++) put_val(32'h1111_0000 + i, 0);
    put_val(2, 0); put_val(32'h240, 0);
    for (int i = 0; i < 2; i++) put_val(32'h2222_0000 + i, 0);
    put_val(0, 0);
    run_boot(32'h040, "R2", sa);
    chk("R2 first read at base", 32'(first_rd_addr), 32'h040);
    chk("R9 start address", sa, 32'h200);
    chk("R6 ctrl word", ctrl_word, 32'h1234_5678);
    chk("R8 write count", wr_count, 5);
    chk("R5 read count", rd_count, 12);
    for (int i = 0; i < 3; i++) chk("R8 sec1 data", mem[32'h200 + i], 32'h1111_0000 + i);
    for (int i = 0; i < 2; i++) chk("R8 sec2 data", mem[32'h240 + i], 32'h2222_0000 + i);
  endtask

  // R4 R5 with 8-bit width and junk upper bits
  task automatic t_narrow8;
    logic [31:0] sa;
    begin_image(32'h080, 32'd8, 8);
    put_val(32'hCAFE_F00D, 32'hABCD_EF00);
    put_val(2, 32'hABCD_EF00); put_val(32'h280, 32'hABCD_EF00);
    put_val(32'h8899_AABB, 32'hABCD_EF00);
    put_val(32'h0102_0304, 32'hABCD_EF00);
    put_val(0, 32'hABCD_EF00);
    run_boot(32'h080, "R4", sa);
    chk("R4 ctrl assembled from bytes", ctrl_word, 32'hCAFE_F00D);
    chk("R9 start address 8-bit", sa, 32'h280);
    chk("R4 data0 8-bit", mem[32'h280], 32'h8899_AABB);
    chk("R4 data1 8-bit", mem[32'h281], 32'h0102_0304);
    chk("R5 read count 8-bit", rd_count, 25);
    chk("R8 write count 8-bit", wr_count, 2);
  endtask

  // R10 R4 R6 R9 with 16-bit width, stalls, latency and stray responses
  task automatic t_half16_stall;
    logic [31:0] sa;
    stall_en = 1; spur_en = 1; lat = 3;
    begin_image(32'h0C0, 32'd16, 16);
    put_val(32'hFFFF_FFFF, 32'h5A5A_0000);
    put_val(1, 32'h5A5A_0000); put_val(32'h2C0, 32'h5A5A_0000);
    put_val(32'h7777_8888, 32'h5A5A_0000);
    put_val(2, 32'h5A5A_0000); put_val(32'h2D0, 32'h5A5A_0000);
    put_val(32'h3333_4444, 32'h5A5A_0000);
    put_val(32'h5555_6666, 32'h5A5A_0000);
    put_val(0, 32'h5A5A_0000);
    run_boot(32'h0C0, "R10", sa);
    stall_en = 0; spur_en = 0; lat = 1;
    chk("R9 second section keeps start", sa, 32'h2C0);
    chk("R6 ctrl all ones no effect", ctrl_word, 32'hFFFF_FFFF);
    chk("R10 data under stalls", mem[32'h2C0], 32'h7777_8888);
    chk("R10 data sec2 word0", mem[32'h2D0], 32'h3333_4444);
    chk("R10 data sec2 word1", mem[32'h2D1], 32'h5555_6666);
    chk("R10 write count", wr_count, 3);
    chk("R5 read count 16-bit", rd_count, 19);
  endtask

  // R3
  task automatic t_bad_width;
    logic [31:0] sa;
    begin_image(32'h100, 32'd12, 12);
    run_boot(32'h100, "R3", sa);
    chk("R3 start zero", sa, 32'd0);
    chk("R3 single read", rd_count, 1);
    chk("R3 no writes", wr_count, 0);
  endtask

  // R7
  task automatic t_empty;
    logic [31:0] sa;
    begin_image(32'h110, 32'd32, 32);
    put_val(32'h0000_0BAD, 0);
    put_val(0, 0);
    run_boot(32'h110, "R7", sa);
    chk("R7 start zero on empty", sa, 32'd0);
    chk("R7 no writes", wr_count, 0);
    chk("R7 read count", rd_count, 3);
    chk("R6 ctrl on empty", ctrl_word, 32'h0000_0BAD);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide32();
    t_narrow8();
    t_half16_stall();
    t_bad_width();
    t_empty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule